// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block drives one port of up to 32 general-purpose pins from a word-wide register bus. Software sets the level each pin drives through a latched output word. That word can be written whole, or changed bit by bit by OR-ing, AND-NOT-ing or XOR-ing a mask into it through three write-only aliases. A direction word chooses, per pin, whether the pin drives (1) or only listens (0).

The pin levels pass through a two-stage synchronizer and are then captured into a read-only input word. Capture runs on every clock while the port enable input is high, and stops while it is low, so the word keeps its last value. Two per-pin qualifier inputs say whether a pin exists on the device and whether it is muxed to a digital function. A pin that fails either qualifier always reads zero in the input word, and its output enable stays low.

Register offsets are byte addresses. Reads return their data one cycle after the read strobe.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output word, the direction word and the input word are all zero, `pin_out` and `pin_oe` are all zero, and every register reads zero.
- R2: A write to offset 0x00 loads the output word with the written value. `pin_out` follows one cycle later, and a read of 0x00 returns the word.
- R3: A write to offset 0x04 ORs the written value into the output word.
- R4: A write to offset 0x08 clears every output-word bit that is 1 in the written value.
- R5: A write to offset 0x0C inverts every output-word bit that is 1 in the written value. Bits written as 0 are unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R7: Offset 0x14 is the read/write direction word (1 = output, 0 = input). Each bit of `pin_oe` is the direction bit ANDed with `pin_present` and `pin_digital`.
- R8: Offset 0x10 returns the input word. With the port enabled, a pin level held steady for three or more clock edges is returned by a read issued after those edges.
- R9: Input-word bits whose `pin_present` or `pin_digital` bit is 0 read as zero, whatever the pin level.
- R10: While `port_en` is low the input word keeps its value and ignores pin changes. Capture resumes when `port_en` returns high.
- R11: Writes to offset 0x10 have no effect on any register or output.
- R12: `bus_rdata` carries read data in the cycle after a read strobe, and is zero in any cycle that does not follow a read strobe.
- R13: Offsets 0x18, 0x1C and any offset not a multiple of four read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, one cycle after the strobe |
| port_en | input | 1 | Port enable; low freezes input capture |
| pin_present | input | NPINS | Per-pin flag: pin exists |
| pin_digital | input | NPINS | Per-pin flag: pin is muxed to a digital function |
| pin_in | input | NPINS | Pin levels (asynchronous) |
| pin_out | output | NPINS | Output word driven to the pins |
| pin_oe | output | NPINS | Per-pin tristate output enable |

## Verification
The hardest case to reach is an input word frozen while the pins change underneath it. To show it, the stimulus has to capture a known value, drop `port_en`, move the pins, and wait out the synchronizer latency. It then reads back the old value, raises the enable again, and watches the new value arrive. Directed sequences do exactly that. Random sequences mix pin patterns with random present and digital masks, waiting at least three edges before every input read. Further random sequences interleave direct, set, clear and toggle writes with reads of the output word, the direction word and the output enables.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFF_ODR = 8'h00;
  localparam logic [7:0] OFF_SET = 8'h04;
  localparam logic [7:0] OFF_CLR = 8'h08;
  localparam logic [7:0] OFF_TGL = 8'h0C;
  localparam logic [7:0] OFF_DIN = 8'h10;
  localparam logic [7:0] OFF_DIR = 8'h14;

  typedef enum logic [2:0] {
    SEL_ODR, SEL_SET, SEL_CLR, SEL_TGL, SEL_DIN, SEL_DIR, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [7:0] off;
  assign off = 8'(addr);

  always_comb begin
    case (off)
      OFF_ODR: sel = SEL_ODR;
      OFF_SET: sel = SEL_SET;
      OFF_CLR: sel = SEL_CLR;
      OFF_TGL: sel = SEL_TGL;
      OFF_DIN: sel = SEL_DIN;
      OFF_DIR: sel = SEL_DIR;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_odr.sv
module gpio_odr #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_direct,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic         wr_tgl,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] odr
);
  logic [N-1:0] nxt;

  // direct, then set, then clear; toggle is applied last
  always_comb begin
    nxt = odr;
    if (wr_direct) nxt = wdata;
    if (wr_set)    nxt = nxt | wdata;
    if (wr_clr)    nxt = nxt & ~wdata;
    if (wr_tgl)    nxt = nxt ^ wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) odr <= '0;
    else     odr <= nxt;
  end
endmodule

// File: rtl/gpio_in_capture.sv
module gpio_in_capture #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] pins,
  output logic [N-1:0] din
);
  logic [N-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     din <= '0;
    else if (en) din <= stage[STAGES-1];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic              port_en,
  input  logic [NPINS-1:0]  pin_present,
  input  logic [NPINS-1:0]  pin_digital,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  reg_sel_e         sel;
  logic [NPINS-1:0] odr;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] din;
  logic [NPINS-1:0] usable;

  assign usable = pin_present & pin_digital;

  gpio_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_odr #(.N(NPINS)) odr_i (
    .clk       (clk),
    .rst       (rst),
    .wr_direct (bus_wr && sel == SEL_ODR),
    .wr_set    (bus_wr && sel == SEL_SET),
    .wr_clr    (bus_wr && sel == SEL_CLR),
    .wr_tgl    (bus_wr && sel == SEL_TGL),
    .wdata     (bus_wdata),
    .odr       (odr)
  );

  gpio_in_capture #(.N(NPINS), .STAGES(SYNC_STAGES)) cap_i (
    .clk  (clk),
    .rst  (rst),
    .en   (port_en),
    .pins (pin_in),
    .din  (din)
  );

  always_ff @(posedge clk) begin
    if (rst)                         dir_q <= '0;
    else if (bus_wr && sel == SEL_DIR) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        SEL_ODR: bus_rdata <= odr;
        SEL_DIN: bus_rdata <= din & usable;
        SEL_DIR: bus_rdata <= dir_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = odr;
  assign pin_oe  = dir_q & usable;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_present,
  input logic [NPINS-1:0]  pin_digital,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);
  logic [7:0] off;
  logic       unmapped;
  assign off      = 8'(bus_addr);
  assign unmapped = (off[1:0] != 2'b00) || (off > 8'h14);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  a_r3_set_or: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 8'h04) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  a_r4_clr_andnot: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 8'h08) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  a_r5_tgl_xor: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 8'h0C) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

  a_r6_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (off == 8'h04 || off == 8'h08 || off == 8'h0C)) |=> bus_rdata == '0);

  a_r7_oe_needs_usable: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~(pin_present & pin_digital)) == '0);

  a_r9_din_masked: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 8'h10) |=> (bus_rdata & ~$past(pin_present & pin_digital)) == '0);

  a_r11_din_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 8'h10) |=> $stable(pin_out));

  a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  a_r13_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && unmapped) |=> $stable(pin_out));

  a_r13_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> bus_rdata == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam int N  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          port_en = 1'b1;
  logic [N-1:0]  pin_present = '1, pin_digital = '1, pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_odr = '0, m_dir = '0;

  always #2 clk = ~clk;

  gpio_port_ctrl #(.NPINS(N), .ADDR_W(AW)) dut_i (.*);

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [N-1:0] exp_oe(logic [N-1:0] dir, logic [N-1:0] p, logic [N-1:0] g);
    return dir & p & g;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] r, held, v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    rd(8'h00, r); check("R1 odr", r, '0);
    rd(8'h14, r); check("R1 dir", r, '0);
    rd(8'h10, r); check("R1 din", r, '0);

    // R2 direct write
    wr(8'h00, 32'hA5A5_0F0F); m_odr = 32'hA5A5_0F0F;
    check("R2 pin_out", pin_out, m_odr);
    rd(8'h00, r); check("R2 readback", r, m_odr);
    // R12 idle cycle after read
    @(negedge clk); check("R12 idle rdata", bus_rdata, '0);
    // R3 R4 R5 directed
    wr(8'h04, 32'h0000_F000); m_odr |= 32'h0000_F000; check("R3 set", pin_out, m_odr);
    wr(8'h08, 32'hA000_000F); m_odr &= ~32'hA000_000F; check("R4 clr", pin_out, m_odr);
    wr(8'h0C, 32'hFFFF_0000); m_odr ^= 32'hFFFF_0000; check("R5 tgl", pin_out, m_odr);
    wr(8'h0C, 32'h0); check("R5 tgl zero", pin_out, m_odr);
    // R6 aliases read zero
    rd(8'h04, r); check("R6 set reads 0", r, '0);
    rd(8'h08, r); check("R6 clr reads 0", r, '0);
    rd(8'h0C, r); check("R6 tgl reads 0", r, '0);
    // R7 direction and oe
    wr(8'h14, 32'hFF00_FF00); m_dir = 32'hFF00_FF00;
    rd(8'h14, r); check("R7 dir readback", r, m_dir);
    check("R7 oe all usable", pin_oe, m_dir);
    pin_present = 32'h0FFF_FFFF; pin_digital = 32'hFFFF_F0FF; #1;
    check("R7 oe masked", pin_oe, exp_oe(m_dir, pin_present, pin_digital));
    pin_present = '1; pin_digital = '1;
    // R11 write to input word ignored
    wr(8'h10, 32'hDEAD_BEEF);
    check("R11 pin_out", pin_out, m_odr);
    rd(8'h14, r); check("R11 dir", r, m_dir);
    rd(8'h10, r); check("R11 din", r, '0);
    // R13 unmapped
    wr(8'h18, 32'h1234_5678); wr(8'h1C, '1); wr(8'h01, '1); wr(8'h16, '1);
    check("R13 pin_out", pin_out, m_odr);
    rd(8'h14, r); check("R13 dir", r, m_dir);
    rd(8'h18, r); check("R13 read 18", r, '0);
    rd(8'h02, r); check("R13 read misaligned", r, '0);

    // R8 capture with latency
    @(negedge clk); pin_in = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    rd(8'h10, r); check("R8 din capture", r, 32'h1357_9BDF);
    // R9 masking
    pin_present = 32'hFFFF_0000; pin_digital = 32'hF0F0_F0F0;
    rd(8'h10, r); check("R9 din masked", r, 32'h1357_9BDF & 32'hF0F0_0000);
    pin_present = '1; pin_digital = '1;
    // R10 freeze
    held = 32'h1357_9BDF;
    @(negedge clk); port_en = 1'b0; pin_in = 32'h2468_ACE0;
    repeat (6) @(negedge clk);
    rd(8'h10, r); check("R10 frozen", r, held);
    port_en = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h10, r); check("R10 resumed", r, 32'h2468_ACE0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 6));
      v  = $urandom;
      case (op)
        0: begin wr(8'h00, v); m_odr = v; end
        1: begin wr(8'h04, v); m_odr |= v; end
        2: begin wr(8'h08, v); m_odr &= ~v; end
        3: begin wr(8'h0C, v); m_odr ^= v; end
        4: begin wr(8'h14, v); m_dir = v; end
        5: begin
          pin_present = $urandom | $urandom;
          pin_digital = $urandom | $urandom;
          @(negedge clk); pin_in = v;
          repeat (3) @(negedge clk);
          rd(8'h10, r); check("R9 random din", r, v & pin_present & pin_digital);
          check("R7 random oe", pin_oe, exp_oe(m_dir, pin_present, pin_digital));
        end
        default: begin
          rd(8'h00, r); check("R2 random odr", r, m_odr);
          rd(8'h14, r); check("R7 random dir", r, m_dir);
        end
      endcase
      if (op < 4) check("R5 random pin_out", pin_out, m_odr);
    end
    finish_run();
  end
endmodule